// File: doc/BRIEF.md
# Series Restorer Compensation Reference Generator

This block produces the three-phase voltage reference that a series voltage restorer must inject so that the load sees an ideal balanced supply. Each sample period a start strobe delivers the grid phase samples, the load phase samples, a unit sine/cosine pair from an upstream synchronisation stage and a peak-amplitude setting. From the sine/cosine pair the block builds an ideal balanced three-phase standard voltage. It takes the standard, the load and the grid voltages through a two-thirds scaled Clarke transform and then a Park rotation.

In the rotating frame the block forms two differences. The first is the load minus the grid. The second is the standard minus the grid. The compensation reference is the second difference minus the first. It is rotated back and expanded to three phases for a downstream PWM stage.

All arithmetic runs on one shared multiplier. A fixed microprogram of 54 multiply-accumulate steps drives it, so the result appears a fixed number of cycles after the strobe. This is far inside a 100 µs sample period at the intended clock. The outputs clamp to the signed full-scale range instead of wrapping, and a flag marks any clamped result.

Top module: `dqr_ref_gen`

## Requirements
- R1: While reset (`rstN` low) is applied, `refValid` and `refSat` are 0 and `refA`, `refB` and `refC` are 0.
- R2: When `start` is sampled high on a rising edge while the block is idle, `refValid` is high after exactly the 55th following rising edge, for one cycle only.
- R3: All samples, `peakAmp`, `syncSin` and `syncCos` are signed two's complement with 15 fraction bits (value = code / 32768). The standard phases are `peakAmp`·sin θ, `peakAmp`·sin(θ − 120°) and `peakAmp`·sin(θ + 120°), derived from the pair by angle addition. Each set passes through α = (2a − b − c)/3 and β = (b − c)/√3. It is then rotated with d = α·cos + β·sin and q = −α·sin + β·cos. The output is the standard dq minus the grid dq, less the load dq minus the grid dq. It is rotated back with α = d·cos − q·sin and β = d·sin + q·cos, and expanded as a = α, b = −α/2 + (√3/2)β, c = −α/2 − (√3/2)β. Each output lies within 16 LSB of this ideal real-valued result.
- R4: The grid samples cancel exactly: two runs that differ only in `gridA`, `gridB` and `gridC` give bit-identical outputs.
- R5: When the load samples equal the standard phases, all three outputs are within 16 LSB of zero.
- R6: An output whose ideal value exceeds the range clamps to +32767 or −32768. `refSat` is 1 with that `refValid` pulse when any phase clamped, and 0 otherwise.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. The running result and its timing are unchanged, and no extra `refValid` pulse follows.
- R8: `refA`, `refB`, `refC` and `refSat` hold their values in every cycle in which `refValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample strobe; captures all inputs when idle |
| gridA | input | DW | Grid phase a sample |
| gridB | input | DW | Grid phase b sample |
| gridC | input | DW | Grid phase c sample |
| loadA | input | DW | Load phase a sample |
| loadB | input | DW | Load phase b sample |
| loadC | input | DW | Load phase c sample |
| peakAmp | input | DW | Peak amplitude of the standard voltage |
| syncSin | input | DW | Sine of the synchronised angle |
| syncCos | input | DW | Cosine of the synchronised angle |
| refA | output | DW | Phase a compensation reference |
| refB | output | DW | Phase b compensation reference |
| refC | output | DW | Phase c compensation reference |
| refValid | output | 1 | One-cycle pulse marking a new reference set |
| refSat | output | 1 | Any phase of the current set was clamped |

## Verification
The embedded properties watch the timing on every cycle. They check the 55-cycle distance from an accepted strobe to the valid pulse and the single-cycle width of that pulse. They check that the step counter advances without disturbance while busy, so late strobes cannot restart it. They check that the outputs hold between pulses and that a raised saturation flag comes with a full-scale output. The numerical content can only be shown by the bench scenarios: agreement with the real-valued transform chain over several angles and amplitudes, exact cancellation of the grid, near-zero output when the load already matches the standard, and clamping in both directions.

// File: rtl/dqr_pkg.sv
package dqr_pkg;

  localparam int NREG    = 34;
  localparam int NSTEP   = 54;
  localparam int LATENCY = NSTEP + 1;

  typedef enum logic [5:0] {
    R_GA, R_GB, R_GC, R_LA, R_LB, R_LC, R_VPK,
    R_SA, R_SB, R_SC, R_TC,
    R_SAL, R_SBE, R_LAL, R_LBE, R_GAL, R_GBE,
    R_SD, R_SQ, R_LD, R_LQ, R_GD, R_GQ,
    R_ED, R_EQ, R_RD, R_RQ, R_CD, R_CQ,
    R_OAL, R_OBE, R_OA, R_OB, R_OC
  } regSel_t;

  typedef enum logic [2:0] {
    C_SIN, C_COS, C_ONE, C_HALF, C_K, C_TT, C_OT, C_IS3
  } coefSel_t;

  typedef enum logic [1:0] { M_LD, M_NEG, M_ADD, M_SUB } accMode_t;

  typedef struct packed {
    logic     capture;
    logic     mac;
    logic     publish;
    regSel_t  src;
    coefSel_t coef;
    regSel_t  dst;
    accMode_t mode;
  } dqrCtl_t;

endpackage

// File: rtl/dqr_sequencer.sv
module dqr_sequencer
  import dqr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dqrCtl_t ctl
);

  localparam int SW = $clog2(NSTEP);
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  logic          busy;
  logic          pubQ;
  logic [SW-1:0] step;
  dqrCtl_t       uop;

  function automatic dqrCtl_t op(regSel_t s, coefSel_t c, regSel_t d, accMode_t m);
    op      = '0;
    op.src  = s;
    op.coef = c;
    op.dst  = d;
    op.mode = m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
      pubQ <= 1'b0;
    end else begin
      pubQ <= busy && (step == LAST);
      if (!busy && start) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (step == LAST) busy <= 1'b0;
        else              step <= step + 1'b1;
      end
    end
  end

  // Microprogram: standard synthesis, three Clarke transforms, three Park
  // rotations, the two-step dq error, inverse Park, inverse Clarke.
  always_comb begin
    uop = op(R_GA, C_ONE, R_GA, M_LD);
    case (int'(step))
      0:  uop = op(R_VPK, C_SIN,  R_SA,  M_LD);
      1:  uop = op(R_VPK, C_COS,  R_TC,  M_LD);
      2:  uop = op(R_SA,  C_HALF, R_SB,  M_NEG);
      3:  uop = op(R_TC,  C_K,    R_SB,  M_SUB);
      4:  uop = op(R_SA,  C_HALF, R_SC,  M_NEG);
      5:  uop = op(R_TC,  C_K,    R_SC,  M_ADD);
      6:  uop = op(R_SA,  C_TT,   R_SAL, M_LD);
      7:  uop = op(R_SB,  C_OT,   R_SAL, M_SUB);
      8:  uop = op(R_SC,  C_OT,   R_SAL, M_SUB);
      9:  uop = op(R_SB,  C_IS3,  R_SBE, M_LD);
      10: uop = op(R_SC,  C_IS3,  R_SBE, M_SUB);
      11: uop = op(R_LA,  C_TT,   R_LAL, M_LD);
      12: uop = op(R_LB,  C_OT,   R_LAL, M_SUB);
      13: uop = op(R_LC,  C_OT,   R_LAL, M_SUB);
      14: uop = op(R_LB,  C_IS3,  R_LBE, M_LD);
      15: uop = op(R_LC,  C_IS3,  R_LBE, M_SUB);
      16: uop = op(R_GA,  C_TT,   R_GAL, M_LD);
      17: uop = op(R_GB,  C_OT,   R_GAL, M_SUB);
      18: uop = op(R_GC,  C_OT,   R_GAL, M_SUB);
      19: uop = op(R_GB,  C_IS3,  R_GBE, M_LD);
      20: uop = op(R_GC,  C_IS3,  R_GBE, M_SUB);
      21: uop = op(R_SAL, C_COS,  R_SD,  M_LD);
      22: uop = op(R_SBE, C_SIN,  R_SD,  M_ADD);
      23: uop = op(R_SAL, C_SIN,  R_SQ,  M_NEG);
      24: uop = op(R_SBE, C_COS,  R_SQ,  M_ADD);
      25: uop = op(R_LAL, C_COS,  R_LD,  M_LD);
      26: uop = op(R_LBE, C_SIN,  R_LD,  M_ADD);
      27: uop = op(R_LAL, C_SIN,  R_LQ,  M_NEG);
      28: uop = op(R_LBE, C_COS,  R_LQ,  M_ADD);
      29: uop = op(R_GAL, C_COS,  R_GD,  M_LD);
      30: uop = op(R_GBE, C_SIN,  R_GD,  M_ADD);
      31: uop = op(R_GAL, C_SIN,  R_GQ,  M_NEG);
      32: uop = op(R_GBE, C_COS,  R_GQ,  M_ADD);
      33: uop = op(R_LD,  C_ONE,  R_ED,  M_LD);
      34: uop = op(R_GD,  C_ONE,  R_ED,  M_SUB);
      35: uop = op(R_LQ,  C_ONE,  R_EQ,  M_LD);
      36: uop = op(R_GQ,  C_ONE,  R_EQ,  M_SUB);
      37: uop = op(R_SD,  C_ONE,  R_RD,  M_LD);
      38: uop = op(R_GD,  C_ONE,  R_RD,  M_SUB);
      39: uop = op(R_SQ,  C_ONE,  R_RQ,  M_LD);
      40: uop = op(R_GQ,  C_ONE,  R_RQ,  M_SUB);
      41: uop = op(R_RD,  C_ONE,  R_CD,  M_LD);
      42: uop = op(R_ED,  C_ONE,  R_CD,  M_SUB);
      43: uop = op(R_RQ,  C_ONE,  R_CQ,  M_LD);
      44: uop = op(R_EQ,  C_ONE,  R_CQ,  M_SUB);
      45: uop = op(R_CD,  C_COS,  R_OAL, M_LD);
      46: uop = op(R_CQ,  C_SIN,  R_OAL, M_SUB);
      47: uop = op(R_CD,  C_SIN,  R_OBE, M_LD);
      48: uop = op(R_CQ,  C_COS,  R_OBE, M_ADD);
      49: uop = op(R_OAL, C_ONE,  R_OA,  M_LD);
      50: uop = op(R_OAL, C_HALF, R_OB,  M_NEG);
      51: uop = op(R_OBE, C_K,    R_OB,  M_ADD);
      52: uop = op(R_OAL, C_HALF, R_OC,  M_NEG);
      53: uop = op(R_OBE, C_K,    R_OC,  M_SUB);
      default: ;
    endcase
    ctl         = uop;
    ctl.capture = !busy && start;
    ctl.mac     = busy;
    ctl.publish = pubQ;
  end

  // R7: once busy, the step counter walks on undisturbed by further strobes
  a_r7_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    busy && (step != LAST) |=> busy && (step == $past(step) + 1'b1));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> (step != '0));

endmodule

// File: rtl/dqr_datapath.sv
module dqr_datapath
  import dqr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dqrCtl_t              ctl,
  input  logic signed [DW-1:0] gridA,
  input  logic signed [DW-1:0] gridB,
  input  logic signed [DW-1:0] gridC,
  input  logic signed [DW-1:0] loadA,
  input  logic signed [DW-1:0] loadB,
  input  logic signed [DW-1:0] loadC,
  input  logic signed [DW-1:0] peakAmp,
  input  logic signed [DW-1:0] syncSin,
  input  logic signed [DW-1:0] syncCos,
  output logic signed [DW-1:0] refA,
  output logic signed [DW-1:0] refB,
  output logic signed [DW-1:0] refC,
  output logic                 refValid,
  output logic                 refSat
);

  localparam int IW = DW + GUARD;
  localparam int CW = DW + 1;
  localparam int FB = DW - 1;
  localparam int PW = IW + CW;
  localparam real SCALE = 2.0 ** FB;

  localparam logic signed [CW-1:0] K_ONE  = CW'(1 << FB);
  localparam logic signed [CW-1:0] K_HALF = CW'(1 << (FB - 1));
  localparam logic signed [CW-1:0] K_S32  = CW'($rtoi(0.8660254037844386 * SCALE + 0.5));
  localparam logic signed [CW-1:0] K_TT   = CW'($rtoi(0.6666666666666667 * SCALE + 0.5));
  localparam logic signed [CW-1:0] K_OT   = CW'($rtoi(0.3333333333333333 * SCALE + 0.5));
  localparam logic signed [CW-1:0] K_IS3  = CW'($rtoi(0.5773502691896258 * SCALE + 0.5));
  localparam logic signed [PW-1:0] RND    = PW'(1) <<< (FB - 1);

  localparam logic signed [IW-1:0] MAXI = IW'((1 << (DW - 1)) - 1);
  localparam logic signed [IW-1:0] MINI = -IW'(1 << (DW - 1));
  localparam logic signed [DW-1:0] MAXD = DW'((1 << (DW - 1)) - 1);
  localparam logic signed [DW-1:0] MIND = DW'(1 << (DW - 1));

  logic signed [IW-1:0] rf [NREG];
  logic signed [DW-1:0] sinQ, cosQ;
  logic signed [CW-1:0] coefV;
  logic signed [PW-1:0] prod;
  logic signed [IW-1:0] prodQ;
  logic signed [IW-1:0] accNext;
  logic signed [IW-1:0] opA, opD;

  function automatic logic signed [DW-1:0] clampD(input logic signed [IW-1:0] x);
    if (x > MAXI)      clampD = MAXD;
    else if (x < MINI) clampD = MIND;
    else               clampD = DW'(x);
  endfunction

  function automatic logic isOver(input logic signed [IW-1:0] x);
    isOver = (x > MAXI) || (x < MINI);
  endfunction

  always_comb begin
    case (ctl.coef)
      C_SIN:   coefV = CW'(sinQ);
      C_COS:   coefV = CW'(cosQ);
      C_ONE:   coefV = K_ONE;
      C_HALF:  coefV = K_HALF;
      C_K:     coefV = K_S32;
      C_TT:    coefV = K_TT;
      C_OT:    coefV = K_OT;
      default: coefV = K_IS3;
    endcase
  end

  // Single shared multiplier with round-half-up rescaling.
  always_comb begin
    opA   = rf[ctl.src];
    opD   = rf[ctl.dst];
    prod  = PW'(opA) * PW'(coefV);
    prodQ = IW'((prod + RND) >>> FB);
    case (ctl.mode)
      M_LD:    accNext = prodQ;
      M_NEG:   accNext = -prodQ;
      M_ADD:   accNext = opD + prodQ;
      default: accNext = opD - prodQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      sinQ <= '0;
      cosQ <= '0;
    end else begin
      if (ctl.capture) begin
        rf[R_GA]  <= IW'(gridA);
        rf[R_GB]  <= IW'(gridB);
        rf[R_GC]  <= IW'(gridC);
        rf[R_LA]  <= IW'(loadA);
        rf[R_LB]  <= IW'(loadB);
        rf[R_LC]  <= IW'(loadC);
        rf[R_VPK] <= IW'(peakAmp);
        sinQ      <= syncSin;
        cosQ      <= syncCos;
      end
      if (ctl.mac) rf[ctl.dst] <= accNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refA     <= '0;
      refB     <= '0;
      refC     <= '0;
      refSat   <= 1'b0;
      refValid <= 1'b0;
    end else begin
      refValid <= ctl.publish;
      if (ctl.publish) begin
        refA   <= clampD(rf[R_OA]);
        refB   <= clampD(rf[R_OB]);
        refC   <= clampD(rf[R_OC]);
        refSat <= isOver(rf[R_OA]) | isOver(rf[R_OB]) | isOver(rf[R_OC]);
      end
    end
  end

  a_r6_sat_at_rail: assert property (@(posedge clk) disable iff (!rstN)
    refValid && refSat |->
      (refA == MAXD) || (refA == MIND) || (refB == MAXD) ||
      (refB == MIND) || (refC == MAXD) || (refC == MIND));

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |-> $stable(refA) && $stable(refB) && $stable(refC) && $stable(refSat));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> !refValid);

endmodule

// File: rtl/dqr_ref_gen.sv
module dqr_ref_gen
  import dqr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic signed [DW-1:0] gridA,
  input  logic signed [DW-1:0] gridB,
  input  logic signed [DW-1:0] gridC,
  input  logic signed [DW-1:0] loadA,
  input  logic signed [DW-1:0] loadB,
  input  logic signed [DW-1:0] loadC,
  input  logic signed [DW-1:0] peakAmp,
  input  logic signed [DW-1:0] syncSin,
  input  logic signed [DW-1:0] syncCos,
  output logic signed [DW-1:0] refA,
  output logic signed [DW-1:0] refB,
  output logic signed [DW-1:0] refC,
  output logic                 refValid,
  output logic                 refSat
);

  localparam int CNTW = $clog2(LATENCY + 1);

  dqrCtl_t ctl;

  dqr_sequencer i_seq (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl)
  );

  dqr_datapath #(.DW(DW), .GUARD(GUARD)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .gridA    (gridA),
    .gridB    (gridB),
    .gridC    (gridC),
    .loadA    (loadA),
    .loadB    (loadB),
    .loadC    (loadC),
    .peakAmp  (peakAmp),
    .syncSin  (syncSin),
    .syncCos  (syncCos),
    .refA     (refA),
    .refB     (refB),
    .refC     (refC),
    .refValid (refValid),
    .refSat   (refSat)
  );

  // Latency window counter for the R2 properties.
  logic [CNTW-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                   latCnt <= '0;
    else if (ctl.capture)                        latCnt <= CNTW'(1);
    else if (latCnt != '0 && latCnt != CNTW'(LATENCY)) latCnt <= latCnt + 1'b1;
    else                                         latCnt <= '0;
  end

  a_r2_latency_fwd: assert property (@(posedge clk) disable iff (!rstN)
    latCnt == CNTW'(LATENCY) |=> refValid);

  a_r2_latency_back: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> $past(latCnt) == CNTW'(LATENCY));

endmodule

// File: tb/test_dqr_ref_gen.sv
`timescale 1ns/1ps
module test_dqr_ref_gen;

  localparam int DW  = 16;
  localparam int TOL = 16;
  localparam int EXP_LAT = 56;  // negedge samples after the start negedge (55 edges)
  localparam real FS = 32768.0;
  localparam real S32 = 0.8660254037844386;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [DW-1:0] gridA = '0, gridB = '0, gridC = '0;
  logic signed [DW-1:0] loadA = '0, loadB = '0, loadC = '0;
  logic signed [DW-1:0] peakAmp = '0, syncSin = '0, syncCos = '0;
  logic signed [DW-1:0] refA, refB, refC;
  logic refValid, refSat;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dqr_ref_gen #(.DW(DW)) i_dqr_ref_gen (
    .clk(clk), .rstN(rstN), .start(start),
    .gridA(gridA), .gridB(gridB), .gridC(gridC),
    .loadA(loadA), .loadB(loadB), .loadC(loadC),
    .peakAmp(peakAmp), .syncSin(syncSin), .syncCos(syncCos),
    .refA(refA), .refB(refB), .refC(refC),
    .refValid(refValid), .refSat(refSat)
  );

  // angle, peak, grid a b c, load a b c, expected saturation flag
  localparam int NV = 7;
  localparam int VT [NV][9] = '{
    '{  0, 16384,      0,      0,     0,      0,      0,      0, 0},
    '{ 30, 20000,   3000,  -1000, -2000,   8000,  -4000,  -4000, 0},
    '{135, 12000,  -5000,   7000,  1000,   1000,   2000,   3000, 0},
    '{250, 25000,  10000, -10000,     0,  -9000,   4000,   5000, 0},
    '{300,  8000,  -7000,   2000,  6000,      0,      0,      0, 0},
    '{ 90, 30000,      0,      0,     0, -30000,  15000,  15000, 1},
    '{270, 30000,   2000,  -1000, -1000,  30000, -15000, -15000, 1}
  };

  function automatic int rnd(input real x);
    rnd = $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
  endfunction

  function automatic int qtrig(input int ang, input bit useCos);
    real r;
    int v;
    r = ang * PI / 180.0;
    v = rnd(FS * (useCos ? $cos(r) : $sin(r)));
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    qtrig = v;
  endfunction

  function automatic int clampI(input int x);
    clampI = (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
  endfunction

  // Real-valued reference chain written from R3.
  task automatic model(input int ang, vpk, ga, gb, gc, la, lb, lc,
                       output int ea, eb, ec, output bit eo);
    real s, c, v, sa, sb, sc;
    real sal, sbe, lal, lbe, gal, gbe, sd, sq, ld, lq, gd, gq;
    real ed, eq, rd, rq, cd, cq, oal, obe, oa, ob, oc;
    int ia, ib, ic;
    s = qtrig(ang, 1'b0) / FS;
    c = qtrig(ang, 1'b1) / FS;
    v = vpk / FS;
    sa = v * s;
    sb = v * (-0.5 * s - S32 * c);
    sc = v * (-0.5 * s + S32 * c);
    sal = (2.0 * sa - sb - sc) / 3.0;       sbe = (sb - sc) / $sqrt(3.0);
    lal = (2.0 * la - lb - lc) / (3.0 * FS); lbe = (lb - lc) / ($sqrt(3.0) * FS);
    gal = (2.0 * ga - gb - gc) / (3.0 * FS); gbe = (gb - gc) / ($sqrt(3.0) * FS);
    sd = sal * c + sbe * s;  sq = -sal * s + sbe * c;
    ld = lal * c + lbe * s;  lq = -lal * s + lbe * c;
    gd = gal * c + gbe * s;  gq = -gal * s + gbe * c;
    ed = ld - gd;  eq = lq - gq;
    rd = sd - gd;  rq = sq - gq;
    cd = rd - ed;  cq = rq - eq;
    oal = cd * c - cq * s;
    obe = cd * s + cq * c;
    oa = oal;
    ob = -0.5 * oal + S32 * obe;
    oc = -0.5 * oal - S32 * obe;
    ia = rnd(oa * FS); ib = rnd(ob * FS); ic = rnd(oc * FS);
    eo = (ia != clampI(ia)) || (ib != clampI(ib)) || (ic != clampI(ic));
    ea = clampI(ia); eb = clampI(ib); ec = clampI(ic);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int b);
    near = ((a - b) <= TOL) && ((b - a) <= TOL);
  endfunction

  task automatic setInputs(input int ang, vpk, ga, gb, gc, la, lb, lc);
    gridA = DW'(ga); gridB = DW'(gb); gridC = DW'(gc);
    loadA = DW'(la); loadB = DW'(lb); loadC = DW'(lc);
    peakAmp = DW'(vpk);
    syncSin = DW'(qtrig(ang, 1'b0));
    syncCos = DW'(qtrig(ang, 1'b1));
  endtask

  task automatic waitValid(output int lat);
    lat = 1;
    while (!refValid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runVec(input int ang, vpk, ga, gb, gc, la, lb, lc, output int lat);
    @(negedge clk);
    setInputs(ang, vpk, ga, gb, gc, la, lb, lc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitValid(lat);
  endtask

  initial begin
    int ea, eb, ec, lat;
    bit eo;
    int ha, hb, hc;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(refValid == 1'b0, "R1 refValid in reset", int'(refValid), 0);
    chk(refSat == 1'b0, "R1 refSat in reset", int'(refSat), 0);
    chk(refA == 0 && refB == 0 && refC == 0, "R1 refA in reset", int'(refA), 0);
    rstN = 1'b1;

    // R3/R6/R2: vector table
    for (int i = 0; i < NV; i++) begin
      runVec(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5], VT[i][6], VT[i][7], lat);
      model(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5], VT[i][6], VT[i][7],
            ea, eb, ec, eo);
      chk(lat == EXP_LAT, "R2 latency", lat, EXP_LAT);
      chk(near(int'(refA), ea), "R3 refA", int'(refA), ea);
      chk(near(int'(refB), eb), "R3 refB", int'(refB), eb);
      chk(near(int'(refC), ec), "R3 refC", int'(refC), ec);
      chk(refSat == VT[i][8][0], "R6 saturation flag", int'(refSat), VT[i][8]);
      @(negedge clk);
      chk(refValid == 1'b0, "R2 pulse width", int'(refValid), 0);
    end

    // R6: exact rails in both directions
    runVec(90, 30000, 0, 0, 0, -30000, 15000, 15000, lat);
    chk(refA == 16'sd32767, "R6 positive rail", int'(refA), 32767);
    runVec(270, 30000, 0, 0, 0, 30000, -15000, -15000, lat);
    chk(refA == -16'sd32768, "R6 negative rail", int'(refA), -32768);

    // R4: grid cancels exactly
    runVec(60, 20000, 0, 0, 0, 5000, -2000, -1000, lat);
    ha = int'(refA); hb = int'(refB); hc = int'(refC);
    runVec(60, 20000, 12000, -8000, 3000, 5000, -2000, -1000, lat);
    chk(int'(refA) == ha, "R4 grid independence a", int'(refA), ha);
    chk(int'(refB) == hb, "R4 grid independence b", int'(refB), hb);
    chk(int'(refC) == hc, "R4 grid independence c", int'(refC), hc);

    // R5: load already equal to the standard
    runVec(200, 22000, 4000, -3000, 6000,
           rnd(22000.0 * $sin(200.0 * PI / 180.0)),
           rnd(22000.0 * $sin(80.0 * PI / 180.0)),
           rnd(22000.0 * $sin(320.0 * PI / 180.0)), lat);
    chk(near(int'(refA), 0), "R5 refA near zero", int'(refA), 0);
    chk(near(int'(refB), 0), "R5 refB near zero", int'(refB), 0);
    chk(near(int'(refC), 0), "R5 refC near zero", int'(refC), 0);

    // R7: strobe while busy is ignored
    @(negedge clk);
    setInputs(30, 20000, 3000, -1000, -2000, 8000, -4000, -4000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    setInputs(250, 25000, 10000, -10000, 0, -9000, 4000, 5000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 11;
    while (!refValid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    model(30, 20000, 3000, -1000, -2000, 8000, -4000, -4000, ea, eb, ec, eo);
    chk(lat == EXP_LAT, "R7 latency unchanged", lat, EXP_LAT);
    chk(near(int'(refA), ea), "R7 refA from first strobe", int'(refA), ea);
    chk(near(int'(refB), eb), "R7 refB from first strobe", int'(refB), eb);
    ha = int'(refA); hb = int'(refB); hc = int'(refC);

    // R8 and R7: outputs hold, no second pulse
    begin
      int pulses = 0;
      bit held = 1'b1;
      for (int k = 0; k < 70; k++) begin
        @(negedge clk);
        if (refValid) pulses++;
        if (int'(refA) != ha || int'(refB) != hb || int'(refC) != hc) held = 1'b0;
      end
      chk(pulses == 0, "R7 no extra pulse", pulses, 0);
      chk(held, "R8 outputs held", int'(refA), ha);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule